// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block produces a signed frequency-offset word that rises and falls linearly in a triangle. A downstream fractional-N divider or numerically controlled oscillator adds the word to its nominal setting, which spreads the energy of the synthesized clock over a narrow band and lowers its spectral peaks. The offset is expressed in units of 0.01 % (100 ppm), so a value of -250 requests a clock 2.5 % below nominal.

Two shapes are offered. In center mode the offset swings symmetrically about zero, starting upward. In down mode it dips from zero to a negative floor and back, never going positive. A four-bit magnitude code selects the peak deviation in discrete steps. The step interval input sets how many system-clock ticks elapse per one-unit move of the offset, and from it the full modulation period follows. For a 30 to 33 kHz modulation rate, the integrator picks the interval from the system clock frequency and the span. When spreading is switched off, the offset walks back to zero at its normal slope and stays there. When spreading is switched back on, a fresh sweep starts from zero.

Top module: `spread_tri_gen`

## Requirements
- R1: During reset and after reset with spreading off, `offset_o` is 0 and `nominal_o` is 1.
- R2: In center mode (`down_mode_i`=0) with code c (0..9), the offset starts at 0, climbs one unit per step to +25*(c+1), descends to -25*(c+1), and climbs back, repeating.
- R3: In down mode (`down_mode_i`=1) with code c (0..9), the offset starts at 0, falls one unit per step to -50*(c+1), rises back to 0, and repeats; it is never positive.
- R4: A magnitude code above 9 behaves exactly as code 9 (peak ±250 in center mode, floor -500 in down mode).
- R5: The offset changes by at most one unit per clock. With a step interval s, the k-th step lands on the s*k-th rising edge after the starting edge. An interval of 0 behaves as 1.
- R6: One full modulation period lasts 100*(c+1)*s clock ticks in both modes. The offset equals -1 one step before the period ends and 0 at its end.
- R7: While spreading is off and the offset is 0, the offset stays 0 whatever the mode, code and interval inputs do.
- R8: When `spread_en_i` falls mid-sweep, the offset moves one unit toward zero per step interval, starting on the first edge that samples the low enable, and then holds 0.
- R9: When `spread_en_i` rises while the block is idle at zero, the sweep restarts from 0 in the mode's initial direction (up for center, down for down mode).
- R10: Mode, code and interval are captured on the edge that starts a sweep. Changes to them during the sweep have no effect on the offset.
- R11: `nominal_o` is 1 exactly when `offset_o` is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en_i | input | 1 | 1 applies modulation, 0 returns to nominal |
| down_mode_i | input | 1 | 0 center spread, 1 down spread |
| mag_code_i | input | CODE_W | Spread magnitude code, clamped to 9 |
| step_ticks_i | input | RATE_W | Clock ticks per one-unit offset step (0 read as 1) |
| offset_o | output | OFF_W | Signed offset in 0.01 % units |
| nominal_o | output | 1 | High while the offset is zero |

## Verification
The bench builds the block with its default parameters: a 10-bit offset, which holds the -500 floor of the largest down-spread setting; a 4-bit code, so codes 10 to 15 exercise the clamp; and a 16-bit interval field. Intervals are driven between 0 and 4 ticks per step, which keeps even the widest setting down to a few thousand cycles per period. Every sweep can therefore be followed through whole periods, including both turning points and the exact return to zero. Random trials also scramble the mode, code and interval inputs partway through a sweep to show that the captured settings hold.

// File: rtl/spread_tri_pkg.sv
package spread_tri_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RET  = 2'd2
  } sweep_state_t;

  // Peak deviation in offset units for a code, clamped to the top level.
  function automatic int unsigned span_units(input int unsigned code,
                                             input int unsigned unit_step,
                                             input int unsigned levels);
    int unsigned c;
    c = (code > levels - 1) ? levels - 1 : code;
    return (c + 1) * unit_step;
  endfunction

endpackage

// File: rtl/spread_tri_cfg.sv
module spread_tri_cfg #(
  parameter int CODE_W = 4,
  parameter int RATE_W = 16,
  parameter int OFF_W  = 10,
  parameter int LEVELS = 10,
  parameter int CSTEP  = 25,
  parameter int DSTEP  = 50
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    down_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic [RATE_W-1:0]       rate_i,
  output logic                    down_q,
  output logic signed [OFF_W-1:0] hi_q,
  output logic signed [OFF_W-1:0] lo_q,
  output logic [RATE_W-1:0]       rate_q
);
  import spread_tri_pkg::*;

  localparam logic [RATE_W-1:0] RATE_ONE = RATE_W'(1);

  logic signed [OFF_W-1:0] amp_c;
  logic signed [OFF_W-1:0] amp_d;

  always_comb begin
    amp_c = OFF_W'(span_units(32'(code_i), CSTEP, LEVELS));
    amp_d = OFF_W'(span_units(32'(code_i), DSTEP, LEVELS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      down_q <= 1'b0;
      hi_q   <= OFF_W'(CSTEP);
      lo_q   <= -OFF_W'(CSTEP);
      rate_q <= RATE_ONE;
    end else if (load) begin
      down_q <= down_i;
      hi_q   <= down_i ? '0 : amp_c;
      lo_q   <= down_i ? -amp_d : -amp_c;
      rate_q <= (rate_i == '0) ? RATE_ONE : rate_i;
    end
  end

endmodule

// File: rtl/spread_tri_tick.sv
module spread_tri_tick #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate_q,
  output logic              step
);
  logic [RATE_W-1:0] cnt_q;

  assign step = !clr && (cnt_q == rate_q - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + RATE_W'(1);
    end
  end

endmodule

// File: rtl/spread_tri_ramp.sv
module spread_tri_ramp #(
  parameter int OFF_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    down_i,
  input  logic                    step,
  input  logic signed [OFF_W-1:0] hi_q,
  input  logic signed [OFF_W-1:0] lo_q,
  output logic                    start,
  output logic                    idle,
  output logic signed [OFF_W-1:0] off_q,
  output logic                    nom_q
);
  import spread_tri_pkg::*;

  localparam logic signed [OFF_W-1:0] ONE = OFF_W'(1);

  sweep_state_t            st_q, st_n;
  logic                    up_q, up_n;
  logic signed [OFF_W-1:0] off_n;
  logic signed [OFF_W-1:0] off_inc;
  logic signed [OFF_W-1:0] off_dec;
  logic signed [OFF_W-1:0] off_home;

  assign off_inc  = off_q + ONE;
  assign off_dec  = off_q - ONE;
  assign off_home = (off_q > 0) ? off_dec : off_inc;
  assign idle     = (st_q == ST_IDLE);

  always_comb begin
    st_n  = st_q;
    up_n  = up_q;
    off_n = off_q;
    start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_i) begin
          st_n  = ST_RUN;
          up_n  = !down_i;
          off_n = '0;
          start = 1'b1;
        end
      end
      ST_RUN: begin
        if (!en_i) begin
          if (off_q == '0) begin
            st_n = ST_IDLE;
          end else begin
            st_n = ST_RET;
            if (step) off_n = off_home;
          end
        end else if (step) begin
          if (up_q) begin
            off_n = off_inc;
            if (off_inc == hi_q) up_n = 1'b0;
          end else begin
            off_n = off_dec;
            if (off_dec == lo_q) up_n = 1'b1;
          end
        end
      end
      ST_RET: begin
        if (off_q == '0) begin
          st_n = ST_IDLE;
        end else if (step) begin
          off_n = off_home;
          if (off_home == '0) st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      up_q  <= 1'b1;
      off_q <= '0;
      nom_q <= 1'b1;
    end else begin
      st_q  <= st_n;
      up_q  <= up_n;
      off_q <= off_n;
      nom_q <= (off_n == '0);
    end
  end

endmodule

// File: rtl/spread_tri_gen.sv
module spread_tri_gen #(
  parameter int CODE_W = 4,
  parameter int RATE_W = 16,
  parameter int OFF_W  = 10,
  parameter int LEVELS = 10,
  parameter int CSTEP  = 25,
  parameter int DSTEP  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spread_en_i,
  input  logic              down_mode_i,
  input  logic [CODE_W-1:0] mag_code_i,
  input  logic [RATE_W-1:0] step_ticks_i,
  output logic [OFF_W-1:0]  offset_o,
  output logic              nominal_o
);
  logic                    start;
  logic                    idle;
  logic                    step;
  logic                    sweep_down;
  logic signed [OFF_W-1:0] hi_q;
  logic signed [OFF_W-1:0] lo_q;
  logic [RATE_W-1:0]       rate_q;
  logic signed [OFF_W-1:0] off_q;

  spread_tri_cfg #(
    .CODE_W(CODE_W), .RATE_W(RATE_W), .OFF_W(OFF_W),
    .LEVELS(LEVELS), .CSTEP(CSTEP), .DSTEP(DSTEP)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(start),
    .down_i(down_mode_i), .code_i(mag_code_i), .rate_i(step_ticks_i),
    .down_q(sweep_down), .hi_q(hi_q), .lo_q(lo_q), .rate_q(rate_q)
  );

  spread_tri_tick #(.RATE_W(RATE_W)) u_tick (
    .clk(clk), .rst(rst), .clr(idle), .rate_q(rate_q), .step(step)
  );

  spread_tri_ramp #(.OFF_W(OFF_W)) u_ramp (
    .clk(clk), .rst(rst), .en_i(spread_en_i), .down_i(down_mode_i),
    .step(step), .hi_q(hi_q), .lo_q(lo_q),
    .start(start), .idle(idle), .off_q(off_q), .nom_q(nominal_o)
  );

  assign offset_o = off_q;

endmodule

// File: rtl/spread_tri_chk.sv
module spread_tri_chk #(
  parameter int OFF_W  = 10,
  parameter int LEVELS = 10,
  parameter int CSTEP  = 25,
  parameter int DSTEP  = 50
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic [OFF_W-1:0] offset_o,
  input logic             nominal_o,
  input logic             sweep_down
);
  logic signed [OFF_W-1:0] off_s;
  assign off_s = $signed(offset_o);

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((int'(off_s) - int'($past(off_s))) <= 1) &&
             ((int'(off_s) - int'($past(off_s))) >= -1));

  assert_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    (int'(off_s) <= LEVELS * CSTEP) && (int'(off_s) >= -(LEVELS * DSTEP)));

  assert_down_nonpos_R3: assert property (@(posedge clk) disable iff (rst)
    sweep_down |-> (off_s <= 0));

  assert_nominal_flag_R11: assert property (@(posedge clk) disable iff (rst)
    nominal_o == (off_s == 0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_i && off_s == 0) |=> (off_s == 0));

  assert_return_pos_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_i && off_s > 0) |=> (off_s <= $past(off_s)) && (off_s >= 0));

  assert_return_neg_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_i && off_s < 0) |=> (off_s >= $past(off_s)) && (off_s <= 0));

endmodule

bind spread_tri_gen spread_tri_chk #(
  .OFF_W(OFF_W), .LEVELS(LEVELS), .CSTEP(CSTEP), .DSTEP(DSTEP)
) u_chk (
  .clk(clk), .rst(rst), .en_i(spread_en_i), .offset_o(offset_o),
  .nominal_o(nominal_o), .sweep_down(sweep_down)
);

// File: tb/spread_tri_gen_bench.sv
module spread_tri_gen_bench;
  localparam int CLK_NS = 10;
  localparam int OFF_W  = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             dmode = 1'b0;
  logic [3:0]       code = '0;
  logic [15:0]      rate = 16'd1;
  logic [OFF_W-1:0] off;
  logic             nom;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_NS/2) clk = ~clk;

  spread_tri_gen u_spread_tri_gen (
    .clk(clk), .rst(rst), .spread_en_i(en), .down_mode_i(dmode),
    .mag_code_i(code), .step_ticks_i(rate), .offset_o(off), .nominal_o(nom)
  );

  function automatic int clampc(input int c);
    return (c > 9) ? 9 : c;
  endfunction

  // Expected offset after k steps of a fresh sweep.
  function automatic int exp_off(input bit dn, input int c, input int k);
    int p, m;
    if (!dn) begin
      p = 25 * (clampc(c) + 1);
      m = k % (4 * p);
      if (m <= p) return m;
      if (m <= 3 * p) return 2 * p - m;
      return m - 4 * p;
    end else begin
      p = 50 * (clampc(c) + 1);
      m = k % (2 * p);
      if (m <= p) return -m;
      return m - 2 * p;
    end
  endfunction

  function automatic int offs();
    return int'($signed(off));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic run_trial(input bit dn, input int c, input int r, input int ncyc,
                           input bit scr, input bit chk_per, input string tag);
    int rr, per, mis, fj, fa, fe, e, a;
    rr  = (r == 0) ? 1 : r;
    per = 100 * (clampc(c) + 1) * rr;
    mis = 0; fj = 0; fa = 0; fe = 0;
    @(negedge clk);
    dmode = dn; code = 4'(c); rate = 16'(r); en = 1'b1;
    for (int j = 0; j <= ncyc; j++) begin
      @(negedge clk);
      if (scr && j == 5) begin
        dmode = 1'($urandom);
        code  = 4'($urandom);
        rate  = 16'(1 + $urandom % 4);
      end
      e = exp_off(dn, c, j / rr);
      a = offs();
      if (a != e || nom != (e == 0)) begin
        if (mis == 0) begin fj = j; fa = a; fe = e; end
        mis++;
      end
      if (chk_per && j == per)      check("R6 period end", a, 0);
      if (chk_per && j == per - rr) check("R6 last step", a, -1);
    end
    total++;
    if (mis != 0) begin
      bad++;
      $display("FAIL %s R11 sweep cycle=%0d act=%0d exp=%0d nominal=%0b", tag, fj, fa, fe, nom);
    end
  endtask

  task automatic go_idle();
    int guard;
    guard = 0;
    @(negedge clk);
    en = 1'b0;
    while (off != '0 && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int nz, mis, e, prev, viol, reached;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    check("R1 offset in reset", offs(), 0);
    check("R1 nominal in reset", int'(nom), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 offset after reset", offs(), 0);
    check("R1 nominal after reset", int'(nom), 1);

    // R7: disabled, inputs wiggle, offset stays zero
    nz = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      dmode = 1'($urandom); code = 4'($urandom); rate = 16'($urandom % 5);
      if (off != '0 || !nom) nz++;
    end
    check("R7 idle hold", nz, 0);

    run_trial(1'b0, 0, 1, 260, 1'b0, 1'b1, "R2 center c0");
    go_idle();
    run_trial(1'b1, 9, 2, 2010, 1'b0, 1'b1, "R3 down c9");
    go_idle();
    run_trial(1'b0, 14, 1, 1010, 1'b1, 1'b1, "R4 R10 clamp center");
    go_idle();
    run_trial(1'b1, 12, 0, 1005, 1'b0, 1'b1, "R4 R5 clamp down rate0");
    go_idle();

    // R8: drop enable at +9, rate 1: exact return
    run_trial(1'b0, 0, 1, 9, 1'b0, 1'b0, "R9 start up");
    en = 1'b0;
    mis = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      e = (9 - k > 0) ? 9 - k : 0;
      if (offs() != e) mis++;
    end
    check("R8 return center rate1 mismatches", mis, 0);
    check("R8 hold zero", offs(), 0);

    // R8: down mode, rate 3, from -20
    run_trial(1'b1, 1, 3, 60, 1'b0, 1'b0, "R9 start down");
    en = 1'b0;
    prev = offs(); viol = 0; reached = 0;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      if (offs() < prev || offs() - prev > 1 || offs() > 0) viol++;
      if (offs() == 0 && reached == 0) reached = k;
      prev = offs();
    end
    check("R8 down slope violations", viol, 0);
    check("R8 down reached zero", int'(reached > 0 && reached <= 63), 1);
    check("R8 down reach time", int'(reached >= 58), 1);

    // R9: re-enable restarts from zero
    run_trial(1'b0, 3, 2, 420, 1'b0, 1'b1, "R9 restart");
    go_idle();

    for (int t = 0; t < 8; t++) begin
      bit dn;
      int c, r, rr;
      dn = 1'($urandom);
      c  = int'($urandom % 16);
      r  = int'($urandom % 4);
      rr = (r == 0) ? 1 : r;
      run_trial(dn, c, r, 100 * (clampc(c) + 1) * rr + 20, 1'b1, 1'b1,
                "R2 R3 R5 R10 random");
      go_idle();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule